// File: doc/BRIEF.md
# Serial DAC Word Loader

This block loads a signed 20-bit code into an external serial DAC over three lines: a latch enable, a shift clock and a data line. Every level change on these lines falls on a slot boundary. A slot is a programmable number of system clocks. A word goes out most significant bit first, and each bit uses two slots. One slot with all lines low follows the last bit. The latch enable then rises again, and that rising edge commits the word inside the DAC. The DAC keeps its output level until the next word is committed.

A request carries a code, a slot length, a state length counted in slots and a return-to-zero enable. The block refuses a code that does not fit in 20-bit two's complement, and it refuses a state length too short to hold a full 41-slot transfer. In both cases it raises an error flag instead of starting. With return-to-zero enabled, the block sends a zero code by itself once the state length has run out, measured from the accepted start, so a gradient pulse has a defined length. With it disabled, the level stays put, and successive requests can build a shaped waveform. After reset the block sends one zero code so that the DAC starts from a known level. A parameter inverts the clock pin for boards that place an inverting isolator in that line.

Top module: `dac_word_loader`

## Requirements
- R1: A request whose code lies in −2^19..2^19−1 (the input sign-extended) is accepted, and the low 20 bits of the code are the word committed to the DAC.
- R2: A request whose code lies outside −2^19..2^19−1 starts no transfer and leaves busy low. It sets err_o from the next cycle, and err_o stays high until the next accepted request clears it.
- R3: Each transfer shifts exactly 20 bits, most significant bit first, and the DAC takes each bit on a high-to-low transition of the internal clock level.
- R4: Bit k uses two consecutive slots. In the first slot LE=1, CLK=1 and DATA=bit. In the second slot LE=1, CLK=0 and DATA=bit. CLK is never high while LE is low.
- R5: After the 20th bit, one slot drives LE, CLK and DATA all low. LE then returns high, which commits the word. When no transfer is running, the lines rest at LE=1, CLK=0, DATA=0.
- R6: A slot lasts slot_len_i system clocks, and a value of 0 counts as 1. A transfer keeps busy_o high for 41 × slot cycles, starting the cycle after the accepted start.
- R7: A request whose state length hold_len_i is below 41 slots is refused in the same way as an out-of-range code.
- R8: busy_o rises in the cycle after an accepted start. A start seen while busy_o is high is ignored: the running transfer, its word and its timing are unchanged.
- R9: With rtz_en_i set, a zero word transfer starts hold_len_i slots after the accepted start. busy_o stays high until that transfer's commit slot ends, for (hold_len_i + 41) × slot cycles in total.
- R10: With rtz_en_i clear, the committed level stays as it is, and no further transfer happens until the next request.
- R11: After reset the block sends one zero word with a slot length of RESET_SLOT clocks, and busy_o stays high until that transfer ends.
- R12: The parameter CLK_INV inverts only the CLK pin. With the default CLK_INV=0, the idle CLK pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| code_i | input | CODE_W | Signed requested code |
| slot_len_i | input | SLOT_W | Slot length in system clocks (0 counts as 1) |
| hold_len_i | input | HOLD_W | State length in slots, measured from the start |
| rtz_en_i | input | 1 | Send a zero word automatically after the state length |
| dac_le_o | output | 1 | DAC latch enable line |
| dac_sclk_o | output | 1 | DAC shift clock line (polarity set by CLK_INV) |
| dac_sdata_o | output | 1 | DAC serial data line |
| busy_o | output | 1 | Transfer or pending zero load in progress |
| err_o | output | 1 | Last request was refused |

## Verification
The bench decodes the three lines as the DAC would and rebuilds each committed word from them. It drives the extreme codes at both range limits and the first values outside them. A design with an off-by-one range check would commit an illegal word or refuse a legal one, and one that shifts the bits in the wrong order would commit a bit-reversed value. A slot length of zero and a state length of 40 slots are both driven. A design that treated zero literally would hang or run a transfer of the wrong length, and one that compared the state length loosely would start a transfer that does not fit. A start pulse during a running transfer and a return-to-zero request with a long state length are also driven. A design that let the second start through would commit the wrong word, and one that counted the state length from the wrong point would release busy in the wrong cycle or skip the zero word.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

    localparam int unsigned WORD_W      = 20;
    localparam int unsigned FRAME_SLOTS = 41;
    localparam int unsigned LAST_SLOT   = FRAME_SLOTS - 1;
    localparam int unsigned IDX_W       = 6;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic le;
        logic sclk;
        logic sdata;
    } lines_t;

    localparam lines_t REST_LINES = '{le: 1'b1, sclk: 1'b0, sdata: 1'b0};

    // True when a 32-bit sign-extended value fits in WORD_W-bit two's complement.
    function automatic logic code_fits(input logic [31:0] v);
        logic [32-WORD_W:0] top;
        top = v[31:WORD_W-1];
        return (&top) | ~(|top);
    endfunction

    // Line levels for one slot of the frame (internal clock polarity).
    function automatic lines_t frame_lines(input logic [IDX_W-1:0] idx,
                                           input logic [WORD_W-1:0] word);
        lines_t           l;
        logic [WORD_W-1:0] sh;
        sh = word << idx[IDX_W-1:1];
        if (idx == IDX_W'(LAST_SLOT)) begin
            l = '{le: 1'b0, sclk: 1'b0, sdata: 1'b0};
        end else begin
            l.le    = 1'b1;
            l.sclk  = ~idx[0];
            l.sdata = sh[WORD_W-1];
        end
        return l;
    endfunction

endpackage

// File: rtl/dwl_slot_timer.sv
module dwl_slot_timer #(
    parameter int unsigned SLOT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SLOT_W-1:0] len_i,
    output logic              tick_o
);
    logic [SLOT_W-1:0] cnt;
    logic [SLOT_W-1:0] eff_len;

    always_comb begin
        eff_len = (len_i == '0) ? SLOT_W'(1) : len_i;
        tick_o  = run && (cnt == eff_len - SLOT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/dwl_req_check.sv
module dwl_req_check
    import dwl_pkg::*;
#(
    parameter int unsigned CODE_W = 24,
    parameter int unsigned HOLD_W = 16
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              ok_o
);
    logic [31:0] sext;
    logic        range_ok;
    logic        len_ok;

    generate
        if (CODE_W < 32) begin : g_ext
            assign sext = {{(32-CODE_W){code_i[CODE_W-1]}}, code_i};
        end else begin : g_cut
            assign sext = code_i[31:0];
        end
    endgenerate

    always_comb begin
        range_ok = code_fits(sext);
        len_ok   = (hold_len_i >= HOLD_W'(FRAME_SLOTS));
        ok_o     = range_ok && len_ok;
    end
endmodule

// File: rtl/dwl_framer.sv
module dwl_framer
    import dwl_pkg::*;
#(
    parameter bit CLK_INV = 1'b0
) (
    input  logic              active,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output logic              le_o,
    output logic              sclk_o,
    output logic              sdata_o
);
    lines_t ln;

    always_comb begin
        ln = active ? frame_lines(idx, word) : REST_LINES;
    end

    assign le_o    = ln.le;
    assign sdata_o = ln.sdata;

    generate
        if (CLK_INV) begin : g_inv
            assign sclk_o = ~ln.sclk;
        end else begin : g_true
            assign sclk_o = ln.sclk;
        end
    endgenerate
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
    import dwl_pkg::*;
#(
    parameter int unsigned CODE_W     = 24,
    parameter int unsigned SLOT_W     = 12,
    parameter int unsigned HOLD_W     = 16,
    parameter int unsigned RESET_SLOT = 2,
    parameter bit          CLK_INV    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SLOT_W-1:0] slot_len_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    input  logic              rtz_en_i,
    output logic              dac_le_o,
    output logic              dac_sclk_o,
    output logic              dac_sdata_o,
    output logic              busy_o,
    output logic              err_o
);
    phase_e            phase;
    logic [IDX_W-1:0]  slot_idx;
    logic [WORD_W-1:0] word_q;
    logic [SLOT_W-1:0] slot_q;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] elapsed;
    logic [HOLD_W-1:0] el_next;
    logic              rtz_q;
    logic              err_q;
    logic              req_ok;
    logic              tick;
    logic              last_slot;
    logic              hold_done;

    dwl_req_check #(.CODE_W(CODE_W), .HOLD_W(HOLD_W)) u_check (
        .code_i     (code_i),
        .hold_len_i (hold_len_i),
        .ok_o       (req_ok)
    );

    dwl_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (phase != PH_IDLE),
        .len_i  (slot_q),
        .tick_o (tick)
    );

    always_comb begin
        el_next   = elapsed + HOLD_W'(1);
        last_slot = (slot_idx == IDX_W'(LAST_SLOT));
        hold_done = (el_next == hold_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_SHIFT;
            slot_idx <= '0;
            word_q   <= '0;
            slot_q   <= SLOT_W'(RESET_SLOT);
            hold_q   <= '0;
            elapsed  <= '0;
            rtz_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        if (req_ok) begin
                            phase    <= PH_SHIFT;
                            slot_idx <= '0;
                            word_q   <= code_i[WORD_W-1:0];
                            slot_q   <= slot_len_i;
                            hold_q   <= hold_len_i;
                            rtz_q    <= rtz_en_i;
                            elapsed  <= '0;
                            err_q    <= 1'b0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (tick) begin
                        elapsed <= el_next;
                        if (!last_slot) begin
                            slot_idx <= slot_idx + IDX_W'(1);
                        end else if (!rtz_q) begin
                            phase <= PH_IDLE;
                        end else if (hold_done) begin
                            slot_idx <= '0;
                            word_q   <= '0;
                            rtz_q    <= 1'b0;
                        end else begin
                            phase <= PH_HOLD;
                        end
                    end
                end
                PH_HOLD: begin
                    if (tick) begin
                        elapsed <= el_next;
                        if (hold_done) begin
                            phase    <= PH_SHIFT;
                            slot_idx <= '0;
                            word_q   <= '0;
                            rtz_q    <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    dwl_framer #(.CLK_INV(CLK_INV)) u_framer (
        .active  (phase == PH_SHIFT),
        .idx     (slot_idx),
        .word    (word_q),
        .le_o    (dac_le_o),
        .sclk_o  (dac_sclk_o),
        .sdata_o (dac_sdata_o)
    );

    assign busy_o = (phase != PH_IDLE);
    assign err_o  = err_q;
endmodule

// File: rtl/dwl_checker.sv
module dwl_checker
    import dwl_pkg::*;
#(
    parameter int unsigned CODE_W  = 24,
    parameter int unsigned HOLD_W  = 16,
    parameter bit          CLK_INV = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [CODE_W-1:0] code_i,
    input logic [HOLD_W-1:0] hold_len_i,
    input logic              dac_le_o,
    input logic              dac_sclk_o,
    input logic              dac_sdata_o,
    input logic              busy_o,
    input logic              err_o
);
    logic [31:0] sext;
    logic        valid_req;
    logic        clk_lvl;

    assign sext      = {{(32-CODE_W){code_i[CODE_W-1]}}, code_i};
    assign valid_req = code_fits(sext) && (hold_len_i >= HOLD_W'(FRAME_SLOTS));
    assign clk_lvl   = dac_sclk_o ^ CLK_INV;

    AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !valid_req) |=> (err_o && !busy_o));          // R2

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && valid_req) |=> (busy_o && !err_o));           // R8

    AST_CLK_NEEDS_LE: assert property (@(posedge clk) disable iff (rst)
        clk_lvl |-> dac_le_o);                                               // R4

    AST_DATA_STEADY_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_lvl) |-> $stable(dac_sdata_o));                            // R4

    AST_LOW_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dac_le_o |-> (!clk_lvl && !dac_sdata_o));                           // R5

    AST_REST_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (dac_le_o && !clk_lvl && !dac_sdata_o));                 // R5

    AST_ERR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (err_o && !busy_o && !start_i) |=> err_o);                           // R2
endmodule

bind dac_word_loader dwl_checker #(
    .CODE_W  (CODE_W),
    .HOLD_W  (HOLD_W),
    .CLK_INV (CLK_INV)
) u_dwl_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .code_i      (code_i),
    .hold_len_i  (hold_len_i),
    .dac_le_o    (dac_le_o),
    .dac_sclk_o  (dac_sclk_o),
    .dac_sdata_o (dac_sdata_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/tb_dac_word_loader.sv
module tb_dac_word_loader;
    localparam int CODE_W = 24;
    localparam int SLOT_W = 12;
    localparam int HOLD_W = 16;
    localparam int RST_SL = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [CODE_W-1:0] code_i = '0;
    logic [SLOT_W-1:0] slot_len_i = '0;
    logic [HOLD_W-1:0] hold_len_i = '0;
    logic              rtz_en_i = 1'b0;
    logic              le, sclk, sdata, busy, err;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // Decoder model of the DAC
    logic       prev_clk = 1'b0;
    logic       prev_le  = 1'b1;
    logic       prev_dat = 1'b0;
    logic [19:0] shreg = '0;
    logic [19:0] dac_val = 'x;
    logic [19:0] prev_val = 'x;
    int nbits = 0;
    int last_nbits = 0;
    int frames = 0;
    int le_viol = 0;
    int latch_viol = 0;

    dac_word_loader #(
        .CODE_W(CODE_W), .SLOT_W(SLOT_W), .HOLD_W(HOLD_W),
        .RESET_SLOT(RST_SL), .CLK_INV(1'b0)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .code_i(code_i),
        .slot_len_i(slot_len_i), .hold_len_i(hold_len_i), .rtz_en_i(rtz_en_i),
        .dac_le_o(le), .dac_sclk_o(sclk), .dac_sdata_o(sdata),
        .busy_o(busy), .err_o(err)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk === 1'b1 && le !== 1'b1) le_viol++;
            if (prev_clk === 1'b1 && sclk === 1'b0) begin
                shreg = {shreg[18:0], sdata};
                nbits++;
            end
            if (prev_le === 1'b0 && le === 1'b1) begin
                if (prev_clk !== 1'b0 || prev_dat !== 1'b0) latch_viol++;
                prev_val   = dac_val;
                dac_val    = shreg;
                last_nbits = nbits;
                nbits      = 0;
                frames++;
            end
        end
        prev_clk = sclk;
        prev_le  = le;
        prev_dat = sdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Issues one request and returns the number of cycles busy stayed high.
    task automatic run_req(input logic [23:0] code, input int slot, input int hold,
                           input bit rtz, output int cyc);
        @(negedge clk);
        code_i = code; slot_len_i = SLOT_W'(slot); hold_len_i = HOLD_W'(hold);
        rtz_en_i = rtz; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (busy && cyc < 50000) begin
            cyc++;
            @(negedge clk);
        end
        #1;
    endtask

    // {code, slot length, accepted}
    localparam int NV = 7;
    localparam logic [36:0] VEC [NV] = '{
        {24'h07FFFF, 12'd1, 1'b1},
        {24'hF80000, 12'd2, 1'b1},
        {24'h080000, 12'd1, 1'b0},
        {24'hF7FFFF, 12'd1, 1'b0},
        {24'h012345, 12'd3, 1'b1},
        {24'hFFFFFF, 12'd1, 1'b1},
        {24'h055555, 12'd2, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cyc;
        int f0;
        logic [19:0] v0;

        // Reset and power-up zero load
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (busy && cyc < 50000) begin
            cyc++;
            @(negedge clk);
        end
        #1;
        chk(cyc == 41*RST_SL, "R11 reset load length", cyc, 41*RST_SL);
        chk(frames == 1, "R11 one reset frame", frames, 1);
        chk(dac_val == 20'd0, "R11 reset word zero", int'(dac_val), 0);
        chk(err == 1'b0, "R11 err clear", int'(err), 0);
        chk(le == 1'b1 && sdata == 1'b0, "R5 rest lines", int'({le, sdata}), 2);
        chk(sclk == 1'b0, "R12 idle clk pin low", int'(sclk), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [23:0] c;
            int sl;
            bit ok;
            c = VEC[i][36:13]; sl = int'(VEC[i][12:1]); ok = VEC[i][0];
            f0 = frames; v0 = dac_val;
            run_req(c, sl, 41, 1'b0, cyc);
            if (ok) begin
                chk(cyc == 41*sl, "R6 transfer length", cyc, 41*sl);
                chk(dac_val == c[19:0], "R1 committed word", int'(dac_val), int'(c[19:0]));
                chk(last_nbits == 20, "R3 bit count", last_nbits, 20);
                chk(frames == f0 + 1, "R1 one frame", frames, f0 + 1);
                chk(err == 1'b0, "R2 err low on accept", int'(err), 0);
            end else begin
                chk(cyc == 0, "R2 no busy", cyc, 0);
                chk(err == 1'b1, "R2 err set", int'(err), 1);
                chk(frames == f0 && dac_val == v0, "R2 no frame", frames, f0);
            end
        end

        // Slot length zero counts as one
        run_req(24'h000ABC, 0, 41, 1'b0, cyc);
        chk(cyc == 41, "R6 zero slot length", cyc, 41);
        chk(dac_val == 20'h00ABC, "R6 word with zero slot", int'(dac_val), 'hABC);

        // Short state length refused, then a good request clears err
        f0 = frames;
        run_req(24'h000111, 1, 40, 1'b0, cyc);
        chk(cyc == 0 && err == 1'b1, "R7 short state refused", cyc, 0);
        chk(frames == f0, "R7 no frame", frames, f0);
        run_req(24'h000222, 1, 41, 1'b0, cyc);
        chk(err == 1'b0, "R2 err cleared by accept", int'(err), 0);
        chk(dac_val == 20'h00222, "R7 limit 41 accepted", int'(dac_val), 'h222);

        // Start while busy is ignored
        f0 = frames;
        @(negedge clk);
        code_i = 24'h000321; slot_len_i = 12'd2; hold_len_i = 16'd41;
        rtz_en_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        repeat (5) begin cyc++; @(negedge clk); end
        code_i = 24'h000123; slot_len_i = 12'd1; start_i = 1'b1;
        cyc++; @(negedge clk);
        start_i = 1'b0;
        while (busy && cyc < 50000) begin
            cyc++;
            @(negedge clk);
        end
        #1;
        chk(cyc == 82, "R8 busy length unchanged", cyc, 82);
        chk(dac_val == 20'h00321, "R8 running word kept", int'(dac_val), 'h321);
        chk(frames == f0 + 1, "R8 single frame", frames, f0 + 1);

        // Return to zero
        f0 = frames;
        run_req(24'h004567, 1, 60, 1'b1, cyc);
        chk(cyc == 101, "R9 busy through zero load", cyc, 101);
        chk(frames == f0 + 2, "R9 two frames", frames, f0 + 2);
        chk(prev_val == 20'h04567, "R9 first word", int'(prev_val), 'h4567);
        chk(dac_val == 20'd0, "R9 zero word", int'(dac_val), 0);

        // Return to zero with state length of exactly one frame, slot 2
        f0 = frames;
        run_req(24'hFFF000, 2, 41, 1'b1, cyc);
        chk(cyc == 164, "R9 back-to-back zero load", cyc, 164);
        chk(prev_val == 20'hFF000 && dac_val == 20'd0, "R9 pair of words",
            int'(prev_val), 'hFF000);

        // No return to zero: level stays
        f0 = frames;
        run_req(24'h001111, 1, 100, 1'b0, cyc);
        repeat (200) @(negedge clk);
        #1;
        chk(frames == f0 + 1, "R10 no further frame", frames, f0 + 1);
        chk(dac_val == 20'h01111 && busy == 1'b0, "R10 level kept", int'(dac_val), 'h1111);

        chk(le_viol == 0, "R4 clk high only with le", le_viol, 0);
        chk(latch_viol == 0, "R5 low slot before latch", latch_viol, 0);

        finish_run();
    end
endmodule